// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block receives stereo audio from an external serial master. The master drives three lines: a bit clock, a word-select line and a serial data line. The block only listens and never drives a clock or framing line. It samples everything on the rising edge of the bit clock and uses that clock as its own. Left and right words share the data line and are told apart by the level of word select.

A 3-bit mode input selects the framing and the word length together. Mode 000 selects the delayed-MSB (I2S) framing, which needs more than 20 bit clocks per channel slot. The other modes select right-justified framing with the word's LSB in the last slot before word select changes. These modes carry words of 16, 18 or 20 bits in slots of 24 or 32 bit clocks. In right-justified framing the line holds the MSB value during the idle slots, so the word length decides where the word starts. Each recovered word is presented as a 20-bit value together with a one-cycle strobe for its channel. A framing violation or the reserved mode code sets a sticky error flag, which blocks all further strobes until the next reset.

Top module: `serial_audio_rx`

## Requirements
- R1: A word received while word select is low is delivered on the left outputs, and a word received while word select is high is delivered on the right outputs.
- R2: A completed word is loaded into its channel's data register at the rising edge where the new word-select level is first sampled. The channel's strobe is high for exactly that one following bit-clock cycle. The two strobes are never high together, and each data output holds its value between strobes.
- R3: Mode encoding: 000 selects I2S. 001, 010 and 011 select right-justified 16, 18 and 20 bits with 24 bit clocks per slot. 101, 110 and 111 select the same word lengths with 32 bit clocks per slot. 100 is reserved.
- R4: In I2S mode the MSB is taken at the second rising edge after a word-select change. The next 20 bits are captured MSB first and delivered left-aligned in the 20-bit output.
- R5: In I2S mode, bits after the 20th in a slot are ignored. A shorter word followed by a low line is delivered left-aligned, with zeros below its LSB.
- R6: In right-justified modes the word is formed from the last N bits of the slot, taken MSB first, where N is the selected length. Earlier (idle) bits have no effect.
- R7: Right-justified words are sign-extended from N bits to 20 bits.
- R8: The number of bit clocks between two word-select changes must be exactly 24 or 32 as the mode selects, or at least 21 in I2S mode. Any other count sets the error flag.
- R9: Selecting the reserved mode 100 sets the error flag within one bit-clock cycle.
- R10: The error flag stays set until reset. While it is set, and at the transfer that sets it, no strobe is produced.
- R11: The first word-select change after reset completes a partial slot and produces no strobe.
- R12: Reset is active low and asynchronous. It clears both data outputs, both strobes and the error flag, and its release takes effect after two bit-clock rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sck | input | 1 | Bit clock from the external master; all sampling on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ws | input | 1 | Word select: low = left slot, high = right slot |
| sd | input | 1 | Serial data, MSB first |
| mode | input | 3 | Framing and word-length select (see R3) |
| left_data | output | 20 | Last delivered left word |
| left_valid | output | 1 | One-cycle strobe: new left word |
| right_data | output | 20 | Last delivered right word |
| right_valid | output | 1 | One-cycle strobe: new right word |
| err | output | 1 | Sticky framing or mode error flag |

## Verification
The bound checker checks the strobe rules on every cycle: strobes are exclusive and one cycle wide, and each strobe matches the word-select change that caused it. It also checks that the data outputs stay stable without a strobe, that the error flag stays set once raised, that the reserved mode sets it at once, and that no strobe appears while it is set. Only the directed scenarios can show that the bits land in the right places. This covers the I2S one-bit delay, left alignment and truncation, the right-justified count-back over idle MSB slots, sign extension for each length, and detection of a wrong slot count.

// File: rtl/serial_audio_rx_pkg.sv
package serial_audio_rx_pkg;

  // width of slot position counter and of per-mode counts
  localparam int CNT_W = 7;

  typedef enum logic [1:0] {
    FMT_I2S  = 2'd0,
    FMT_RJ   = 2'd1,
    FMT_RSVD = 2'd2
  } fmt_e;

  typedef struct packed {
    fmt_e             fmt;
    logic [CNT_W-1:0] wlen;   // word length in bits
    logic [CNT_W-1:0] slots;  // expected bit clocks per slot (right-justified)
  } mode_cfg_t;

endpackage

// File: rtl/serial_audio_rx_rst_sync.sv
module serial_audio_rx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/serial_audio_rx_mode_dec.sv
module serial_audio_rx_mode_dec
  import serial_audio_rx_pkg::*;
#(
  parameter int SAMPLE_W    = 20,
  parameter int SLOTS_SHORT = 24,
  parameter int SLOTS_LONG  = 32,
  parameter int WLEN_A      = 16,
  parameter int WLEN_B      = 18,
  parameter int WLEN_C      = 20
) (
  input  logic [2:0] mode_i,
  output mode_cfg_t  cfg_o
);
  localparam logic [CNT_W-1:0] L_A   = CNT_W'(WLEN_A);
  localparam logic [CNT_W-1:0] L_B   = CNT_W'(WLEN_B);
  localparam logic [CNT_W-1:0] L_C   = CNT_W'(WLEN_C);
  localparam logic [CNT_W-1:0] L_MAX = CNT_W'(SAMPLE_W);
  localparam logic [CNT_W-1:0] S_SH  = CNT_W'(SLOTS_SHORT);
  localparam logic [CNT_W-1:0] S_LG  = CNT_W'(SLOTS_LONG);

  always_comb begin
    cfg_o.fmt   = FMT_RJ;
    cfg_o.wlen  = L_MAX;
    cfg_o.slots = mode_i[2] ? S_LG : S_SH;
    case (mode_i[1:0])
      2'b00: begin
        cfg_o.fmt   = mode_i[2] ? FMT_RSVD : FMT_I2S;
        cfg_o.slots = '0;
      end
      2'b01:   cfg_o.wlen = L_A;
      2'b10:   cfg_o.wlen = L_B;
      default: cfg_o.wlen = L_C;
    endcase
  end
endmodule

// File: rtl/serial_audio_rx_framer.sv
module serial_audio_rx_framer
  import serial_audio_rx_pkg::*;
#(
  parameter int SAMPLE_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ws_i,
  input  mode_cfg_t        cfg_i,
  output logic             ws_edge_o,
  output logic             ch_o,
  output logic             xfer_o,
  output logic             err_o,
  output logic [CNT_W-1:0] pos_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] I2S_MIN = CNT_W'(SAMPLE_W);

  logic             ws_q, ws_d;
  logic             primed_q, primed_d;
  logic             armed_q, armed_d;
  logic             err_q, err_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ws_edge, slot_bad, xfer;

  // next-state logic
  always_comb begin
    ws_edge  = primed_q && (ws_i != ws_q);
    case (cfg_i.fmt)
      FMT_I2S: slot_bad = (cnt_q <= I2S_MIN);
      FMT_RJ:  slot_bad = (cnt_q != cfg_i.slots);
      default: slot_bad = 1'b1;
    endcase
    err_d    = err_q || (cfg_i.fmt == FMT_RSVD) || (ws_edge && armed_q && slot_bad);
    xfer     = ws_edge && armed_q && !err_d;
    ws_d     = ws_i;
    primed_d = 1'b1;
    armed_d  = armed_q || ws_edge;
    if (ws_edge)               cnt_d = CNT_W'(1);
    else if (cnt_q == CNT_MAX) cnt_d = cnt_q;
    else                       cnt_d = cnt_q + CNT_W'(1);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_q     <= 1'b0;
      primed_q <= 1'b0;
      armed_q  <= 1'b0;
      err_q    <= 1'b0;
      cnt_q    <= '0;
    end else begin
      ws_q     <= ws_d;
      primed_q <= primed_d;
      armed_q  <= armed_d;
      err_q    <= err_d;
      cnt_q    <= cnt_d;
    end
  end

  assign ws_edge_o = ws_edge;
  assign ch_o      = ws_q;
  assign xfer_o    = xfer;
  assign err_o     = err_q;
  assign pos_o     = ws_edge ? '0 : cnt_q;
endmodule

// File: rtl/serial_audio_rx_shifter.sv
module serial_audio_rx_shifter
  import serial_audio_rx_pkg::*;
#(
  parameter int SAMPLE_W = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sd_i,
  input  logic [CNT_W-1:0]    pos_i,
  input  mode_cfg_t           cfg_i,
  output logic [SAMPLE_W-1:0] word_o
);
  localparam int               IDX_W = $clog2(SAMPLE_W);
  localparam logic [CNT_W-1:0] POS_LAST = CNT_W'(SAMPLE_W);

  logic [SAMPLE_W-1:0] i2s_q, i2s_d;
  logic [SAMPLE_W-1:0] rj_q, rj_d;
  logic                i2s_en;
  logic [IDX_W-1:0]    msb_idx;
  logic                msb_bit;
  logic [SAMPLE_W-1:0] rj_ext;

  // I2S: capture slot positions 1..SAMPLE_W only
  always_comb begin
    i2s_en = (pos_i >= CNT_W'(1)) && (pos_i <= POS_LAST);
    i2s_d  = {i2s_q[SAMPLE_W-2:0], sd_i};
    rj_d   = {rj_q[SAMPLE_W-2:0], sd_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i2s_q <= '0;
      rj_q  <= '0;
    end else begin
      if (i2s_en) i2s_q <= i2s_d;
      rj_q <= rj_d;
    end
  end

  // right-justified: newest wlen bits, sign-extended
  always_comb begin
    msb_idx = IDX_W'(cfg_i.wlen - CNT_W'(1));
    msb_bit = rj_q[msb_idx];
    for (int b = 0; b < SAMPLE_W; b++) begin
      rj_ext[b] = (CNT_W'(b) < cfg_i.wlen) ? rj_q[b] : msb_bit;
    end
    word_o = (cfg_i.fmt == FMT_I2S) ? i2s_q : rj_ext;
  end
endmodule

// File: rtl/serial_audio_rx_outreg.sv
module serial_audio_rx_outreg #(
  parameter int SAMPLE_W = 20,
  parameter int N_CH     = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           xfer_i,
  input  logic [CH_W-1:0]                ch_i,
  input  logic [SAMPLE_W-1:0]            word_i,
  output logic [N_CH-1:0][SAMPLE_W-1:0]  data_o,
  output logic [N_CH-1:0]                valid_o
);
  localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic                hit;
    logic                valid_q, valid_d;
    logic [SAMPLE_W-1:0] data_q, data_d;

    always_comb begin
      hit     = xfer_i && (ch_i == CH_W'(c));
      valid_d = hit;
      data_d  = hit ? word_i : data_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q <= 1'b0;
        data_q  <= '0;
      end else begin
        valid_q <= valid_d;
        data_q  <= data_d;
      end
    end

    assign valid_o[c] = valid_q;
    assign data_o[c]  = data_q;
  end
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import serial_audio_rx_pkg::*;
#(
  parameter int SAMPLE_W    = 20,
  parameter int SLOTS_SHORT = 24,
  parameter int SLOTS_LONG  = 32,
  parameter int WLEN_A      = 16,
  parameter int WLEN_B      = 18,
  parameter int WLEN_C      = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic                sck,
  input  logic                rst_n,
  input  logic                ws,
  input  logic                sd,
  input  logic [2:0]          mode,
  output logic [SAMPLE_W-1:0] left_data,
  output logic                left_valid,
  output logic [SAMPLE_W-1:0] right_data,
  output logic                right_valid,
  output logic                err
);
  localparam int N_CH = 2;

  logic                          rst_sync_n;
  mode_cfg_t                     cfg;
  logic                          ws_edge, ch_done, xfer;
  logic [CNT_W-1:0]              pos;
  logic [SAMPLE_W-1:0]           word;
  logic [N_CH-1:0][SAMPLE_W-1:0] data;
  logic [N_CH-1:0]               valid;

  serial_audio_rx_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(sck), .arst_n(rst_n), .rst_n_o(rst_sync_n)
  );

  serial_audio_rx_mode_dec #(
    .SAMPLE_W(SAMPLE_W), .SLOTS_SHORT(SLOTS_SHORT), .SLOTS_LONG(SLOTS_LONG),
    .WLEN_A(WLEN_A), .WLEN_B(WLEN_B), .WLEN_C(WLEN_C)
  ) u_dec (
    .mode_i(mode), .cfg_o(cfg)
  );

  serial_audio_rx_framer #(.SAMPLE_W(SAMPLE_W)) u_framer (
    .clk(sck), .rst_n(rst_sync_n), .ws_i(ws), .cfg_i(cfg),
    .ws_edge_o(ws_edge), .ch_o(ch_done), .xfer_o(xfer), .err_o(err), .pos_o(pos)
  );

  serial_audio_rx_shifter #(.SAMPLE_W(SAMPLE_W)) u_shift (
    .clk(sck), .rst_n(rst_sync_n), .sd_i(sd), .pos_i(pos), .cfg_i(cfg), .word_o(word)
  );

  serial_audio_rx_outreg #(.SAMPLE_W(SAMPLE_W), .N_CH(N_CH)) u_out (
    .clk(sck), .rst_n(rst_sync_n), .xfer_i(xfer), .ch_i(ch_done),
    .word_i(word), .data_o(data), .valid_o(valid)
  );

  assign left_data   = data[0];
  assign right_data  = data[1];
  assign left_valid  = valid[0];
  assign right_valid = valid[1];
endmodule

// File: rtl/serial_audio_rx_chk.sv
module serial_audio_rx_chk #(
  parameter int SAMPLE_W = 20
) (
  input logic                sck,
  input logic                rst_sync_n,
  input logic                ws,
  input logic [2:0]          mode,
  input logic [SAMPLE_W-1:0] left_data,
  input logic                left_valid,
  input logic [SAMPLE_W-1:0] right_data,
  input logic                right_valid,
  input logic                err
);
  // R2
  strobe_excl_chk: assert property (@(posedge sck) disable iff (!rst_sync_n)
    !(left_valid && right_valid));
  // R2
  left_pulse_chk: assert property (@(posedge sck) disable iff (!rst_sync_n)
    left_valid |=> !left_valid);
  // R2
  right_pulse_chk: assert property (@(posedge sck) disable iff (!rst_sync_n)
    right_valid |=> !right_valid);
  // R2
  left_hold_chk: assert property (@(posedge sck) disable iff (!rst_sync_n)
    !left_valid |-> $stable(left_data));
  // R2
  right_hold_chk: assert property (@(posedge sck) disable iff (!rst_sync_n)
    !right_valid |-> $stable(right_data));
  // R1
  left_side_chk: assert property (@(posedge sck) disable iff (!rst_sync_n)
    left_valid |-> ($past(ws) == 1'b1 && $past(ws, 2) == 1'b0));
  // R1
  right_side_chk: assert property (@(posedge sck) disable iff (!rst_sync_n)
    right_valid |-> ($past(ws) == 1'b0 && $past(ws, 2) == 1'b1));
  // R9
  reserved_mode_chk: assert property (@(posedge sck) disable iff (!rst_sync_n)
    (mode == 3'b100) |=> err);
  // R10
  err_sticky_chk: assert property (@(posedge sck) disable iff (!rst_sync_n)
    err |=> err);
  // R10
  err_mute_chk: assert property (@(posedge sck) disable iff (!rst_sync_n)
    err |-> (!left_valid && !right_valid));
endmodule

bind serial_audio_rx serial_audio_rx_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .sck(sck), .rst_sync_n(rst_sync_n), .ws(ws), .mode(mode),
  .left_data(left_data), .left_valid(left_valid),
  .right_data(right_data), .right_valid(right_valid), .err(err)
);

// File: tb/serial_audio_rx_bench.sv
module serial_audio_rx_bench;
  logic        sck = 1'b0;
  logic        rst_n;
  logic        ws, sd;
  logic [2:0]  mode;
  logic [19:0] left_data, right_data;
  logic        left_valid, right_valid, err;

  int nchk  = 0;
  int nfail = 0;

  always #10 sck = ~sck;

  serial_audio_rx u_serial_audio_rx (
    .sck(sck), .rst_n(rst_n), .ws(ws), .sd(sd), .mode(mode),
    .left_data(left_data), .left_valid(left_valid),
    .right_data(right_data), .right_valid(right_valid), .err(err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [19:0] act, input logic [19:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // expected output word from the requirements
  function automatic logic [19:0] model(input bit i2s, input int wlen, input logic [23:0] w);
    logic [19:0] r;
    r = '0;
    for (int b = 0; b < 20; b++) begin
      if (i2s) begin
        int src = wlen - 1 - b;
        r[19-b] = (src >= 0) ? w[src] : 1'b0;
      end else begin
        r[b] = (b < wlen) ? w[b] : w[wlen-1];
      end
    end
    return r;
  endfunction

  function automatic logic [23:0] gen(input int h, input int seed, input int wlen);
    logic [31:0] v;
    if (h == 0) return 24'hFFFFFF;
    if (h == 1) return 24'(1) << (wlen - 1);
    v = 32'(seed) * 32'h9E3779B1 + 32'(h) * 32'h7F4A7C15;
    return v[27:4];
  endfunction

  task automatic do_reset(input logic [2:0] m, input string req);
    @(negedge sck);
    rst_n = 1'b0; ws = 1'b1; sd = 1'b0; mode = m;
    repeat (3) @(negedge sck);
    // R12 outputs cleared while reset is held
    chk(left_data == '0 && right_data == '0, "R12", "reset data", left_data | right_data, '0);
    chk(!left_valid && !right_valid && !err, req, "reset strobes/err",
        20'({left_valid, right_valid, err}), '0);
    rst_n = 1'b1;
    repeat (4) @(negedge sck);
  endtask

  // one slot; checks the transfer of the previous slot at position 1
  task automatic half(input logic wsv, input int slots, input bit i2s, input int wlen,
                      input logic [23:0] w, input bit expv, input logic [19:0] expd,
                      input string req);
    for (int p = 0; p < slots; p++) begin
      logic b;
      @(negedge sck);
      if (p == 1) begin
        logic lv, ov;
        logic [19:0] d;
        lv = wsv ? left_valid : right_valid;
        ov = wsv ? right_valid : left_valid;
        d  = wsv ? left_data : right_data;
        chk(lv == expv, "R1", {req, " strobe"}, 20'(lv), 20'(expv));
        chk(!ov, "R1", "other channel strobe", 20'(ov), '0);
        if (expv) chk(d == expd, req, "word", d, expd);
      end
      if (p == 2) chk(!left_valid && !right_valid, "R2", "strobe width",
                      20'({left_valid, right_valid}), '0);
      if (i2s) b = (p >= 1 && p <= wlen) ? w[wlen-p] : 1'b0;
      else     b = (p >= slots - wlen) ? w[wlen-1-(p-(slots-wlen))] : w[wlen-1];
      ws = wsv; sd = b;
    end
  endtask

  task automatic run_mode(input logic [2:0] m, input int slots, input int wlen,
                          input int npairs, input int seed, input string req);
    bit          i2s;
    logic [23:0] prev;
    i2s  = (m == 3'b000);
    prev = '0;
    do_reset(m, "R12");
    for (int h = 0; h <= 2 * npairs; h++) begin
      logic [23:0] w;
      w = gen(h, seed, wlen);
      // R11: h==0 follows the first edge after reset, no strobe
      half(1'(h % 2), slots, i2s, wlen, w, h >= 1, model(i2s, wlen, prev),
           (h == 0) ? "R11" : req);
      prev = w;
    end
    chk(!err, req, "no error", 20'(err), '0);
  endtask

  task automatic t_slot_mismatch;
    do_reset(3'b001, "R12");
    for (int h = 0; h < 3; h++) half(1'(h % 2), 32, 1'b0, 16, gen(h, 5, 16), 1'b0, '0, "R8");
    chk(err, "R8", "err on 32-slot in 24-slot mode", 20'(err), 20'(1));
    for (int h = 3; h < 7; h++) half(1'(h % 2), 24, 1'b0, 16, gen(h, 5, 16), 1'b0, '0, "R10");
    chk(err, "R10", "err sticky", 20'(err), 20'(1));
  endtask

  task automatic t_i2s_short;
    do_reset(3'b000, "R12");
    for (int h = 0; h < 3; h++) half(1'(h % 2), 20, 1'b1, 20, gen(h, 9, 20), 1'b0, '0, "R8");
    chk(err, "R8", "err on 20-slot I2S", 20'(err), 20'(1));
  endtask

  task automatic t_reserved;
    do_reset(3'b100, "R12");
    chk(err, "R9", "err on reserved mode", 20'(err), 20'(1));
    for (int h = 0; h < 3; h++) half(1'(h % 2), 32, 1'b0, 20, gen(h, 3, 20), 1'b0, '0, "R9");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge sck);
    nfail++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin : main
    rst_n = 1'b0; ws = 1'b1; sd = 1'b0; mode = 3'b000;
    run_mode(3'b000, 32, 20, 3, 1, "R4 R3");
    run_mode(3'b000, 32, 16, 2, 2, "R5");
    run_mode(3'b000, 40, 24, 2, 3, "R5");
    run_mode(3'b001, 24, 16, 3, 4, "R6 R7 R3");
    run_mode(3'b010, 24, 18, 2, 5, "R6 R7 R3");
    run_mode(3'b011, 24, 20, 2, 6, "R6 R3");
    run_mode(3'b101, 32, 16, 2, 7, "R6 R7 R3");
    run_mode(3'b110, 32, 18, 2, 8, "R7 R3");
    run_mode(3'b111, 32, 20, 2, 9, "R6 R3");
    t_slot_mismatch();
    t_i2s_short();
    t_reserved();
    // R10 reset clears the sticky flag and delivery resumes
    run_mode(3'b001, 24, 16, 1, 11, "R10");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule